// File: doc/BRIEF.md
# Exclusive Two-Level Read Cache

This block holds two levels of cached line data, each with its own tags. No line address is ever present in both levels at once. A read request carries a line address and is accepted through a valid/ready handshake. The controller looks in the first level, then in the second level. If both miss, it issues one request on a simple memory port and waits for the memory's valid strobe. Each request ends with a one-cycle response that carries the line data and a 2-bit code saying where the line was found.

The first level is small and set-associative. The second level has higher associativity and may hold fewer lines than the first. Both levels replace the least recently used way of a set, and an empty way is always chosen before a valid one.

A line from memory is written into the first level only. When the second level hits, the line moves up into the first level and leaves the second. In both of those cases, any line the first level displaces drops into the second level instead of being lost. A line that the second level displaces is discarded, because there is no dirty state. Every size is a parameter, so the whole structure lives in registers.

Top module: `cx_excl_cache`

## Requirements
- R1: After reset `req_ready` is 1, while `resp_valid` and `mem_req_valid` are 0. Both levels are empty, so the first request to any address misses.
- R2: A request for a line held in the first level produces `resp_valid` in the second cycle after acceptance, with `resp_code` = 0. No memory request is made.
- R3: When both levels miss, `mem_req_valid` rises with `mem_req_addr` equal to the requested address. It stays high with a stable address until `mem_rsp_valid` arrives. `req_ready` is 0 meanwhile, and only one memory request is outstanding at a time. The response follows in the next cycle with `resp_code` = 2.
- R4: A line fetched from memory is placed in the first level, so an immediate repeat request returns code 0.
- R5: When the first level's set is full, the line it displaces moves into the second level. A later request for that line returns code 1.
- R6: A second-level hit answers in the second cycle after acceptance with `resp_code` = 1 and no memory request. The line moves to the first level, so a repeat returns code 0. The first level's displaced line moves down and returns code 1.
- R7: No line address is valid in both levels, and none is valid twice within a level.
- R8: In each level, replacement takes an empty way first and otherwise the least recently used way of the set. Hits in the first level and insertions into either level both count as use.
- R9: A line pushed out of a full second-level set is dropped, and its next request returns code 2.
- R10: `resp_data` always equals the data that memory supplied for that address, whichever level answers.
- R11: The hierarchy retains up to L1_WAYS + L2_WAYS distinct lines that map to one first-level set and one second-level set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_addr | input | ADDR_W | Line address of the request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | DATA_W | Line data returned |
| resp_code | output | 2 | 0 first-level hit, 1 second-level hit, 2 miss in both |
| mem_req_valid | output | 1 | Memory fetch outstanding |
| mem_req_addr | output | ADDR_W | Line address to fetch |
| mem_rsp_valid | input | 1 | Memory data strobe |
| mem_rsp_data | input | DATA_W | Line data from memory |

## Verification
The hardest situation to reach is a full second-level set that must drop a line at the same moment as it takes a victim from the first level. A second-level hit whose first-level victim maps to a different second-level set is also difficult to reach. Directed sequences push more distinct lines than both levels can hold through one first-level set and one second-level set. They then probe the oldest line and an intermediate one. Random traffic over a small address pool keeps both levels near full, so swaps, spills and drops interleave. A bench model of per-set recency lists predicts every outcome code.

// File: rtl/cx_pkg.sv
package cx_pkg;
   typedef enum logic [1:0] {
      CX_L1_HIT = 2'd0,
      CX_L2_HIT = 2'd1,
      CX_MISS   = 2'd2
   } cx_outcome_e;

   typedef enum logic [1:0] {
      CX_IDLE = 2'd0,
      CX_LOOK = 2'd1,
      CX_MEM  = 2'd2
   } cx_state_e;
endpackage

// File: rtl/cx_lru_pick.sv
module cx_lru_pick #(
   parameter int WAYS = 2,
   localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]    free_ways,
   input  logic [WAYS*WW-1:0] ranks,
   output logic [WW-1:0]      pick_way,
   output logic               pick_free
);
   generate
      if (WAYS == 1) begin : g_single
         assign pick_way  = '0;
         assign pick_free = free_ways[0];
         logic [WW-1:0] unused_rank;
         assign unused_rank = ranks[WW-1:0];
      end else begin : g_multi
         always_comb begin
            pick_free = |free_ways;
            pick_way  = '0;
            if (pick_free) begin
               for (int w = WAYS - 1; w >= 0; w--)
                  if (free_ways[w]) pick_way = WW'(w);
            end else begin
               for (int w = 0; w < WAYS; w++)
                  if (ranks[w*WW +: WW] == WW'(WAYS - 1)) pick_way = WW'(w);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cx_level.sv
module cx_level #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int SETS   = 2,
   parameter int WAYS   = 2,
   localparam int SW    = (SETS > 1) ? $clog2(SETS) : 1,
   localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [WW-1:0]     lk_way,
   output logic [DATA_W-1:0] lk_data,
   input  logic              touch_en,
   input  logic              kill_en,
   input  logic              ins_en,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [DATA_W-1:0] ins_data,
   output logic              ev_valid,
   output logic [ADDR_W-1:0] ev_addr,
   output logic [DATA_W-1:0] ev_data
);
   logic              vld [SETS][WAYS];
   logic [ADDR_W-1:0] tg  [SETS][WAYS];
   logic [DATA_W-1:0] dat [SETS][WAYS];
   logic [WW-1:0]     rk  [SETS][WAYS];

   logic [SW-1:0] ls, is;
   generate
      if (SETS > 1) begin : g_idx
         assign ls = lk_addr[SW-1:0];
         assign is = ins_addr[SW-1:0];
      end else begin : g_noidx
         assign ls = '0;
         assign is = '0;
      end
   endgenerate

   logic [WAYS-1:0] hv;
   always_comb begin
      lk_way  = '0;
      lk_data = '0;
      for (int w = 0; w < WAYS; w++) begin
         hv[w] = vld[ls][w] && (tg[ls][w] == lk_addr);
         if (hv[w]) begin
            lk_way  = WW'(w);
            lk_data = dat[ls][w];
         end
      end
   end
   assign lk_hit = |hv;

   logic [WAYS-1:0]    free_m;
   logic [WAYS*WW-1:0] rk_flat;
   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         free_m[w] = !vld[is][w] || (kill_en && (is == ls) && (lk_way == WW'(w)));
         rk_flat[w*WW +: WW] = rk[is][w];
      end
   end

   logic [WW-1:0] pw;
   logic          pfree;
   cx_lru_pick #(.WAYS(WAYS)) u_pick (
      .free_ways(free_m),
      .ranks    (rk_flat),
      .pick_way (pw),
      .pick_free(pfree)
   );

   assign ev_valid = !pfree;
   assign ev_addr  = tg[is][pw];
   assign ev_data  = dat[is][pw];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
               vld[s][w] <= 1'b0;
               rk[s][w]  <= WW'(w);
            end
      end else begin
         if (kill_en) vld[ls][lk_way] <= 1'b0;
         if (touch_en) begin
            for (int w = 0; w < WAYS; w++)
               if (rk[ls][w] < rk[ls][lk_way]) rk[ls][w] <= rk[ls][w] + 1'b1;
            rk[ls][lk_way] <= '0;
         end
         if (ins_en) begin
            vld[is][pw] <= 1'b1;
            for (int w = 0; w < WAYS; w++)
               if (rk[is][w] < rk[is][pw]) rk[is][w] <= rk[is][w] + 1'b1;
            rk[is][pw] <= '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (ins_en) begin
         tg[is][pw]  <= ins_addr;
         dat[is][pw] <= ins_data;
      end
   end

   // R7
   dup_line_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hv))
      else $error("line present in two ways of one set");
   // R8
   one_op_chk: assert property (@(posedge clk) disable iff (!rst_n) !(touch_en && ins_en))
      else $error("touch and insert in the same cycle");
   // R8
   ins_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !kill_en) |=> (lk_addr != $past(ins_addr)) || lk_hit || $past(lk_addr) != lk_addr)
      else $error("inserted line not found");
endmodule

// File: rtl/cx_excl_cache.sv
module cx_excl_cache
   import cx_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 16,
   parameter int L1_SETS = 2,
   parameter int L1_WAYS = 2,
   parameter int L2_SETS = 4,
   parameter int L2_WAYS = 16,
   localparam int W1W    = (L1_WAYS > 1) ? $clog2(L1_WAYS) : 1,
   localparam int W2W    = (L2_WAYS > 1) ? $clog2(L2_WAYS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_data,
   output logic [1:0]        resp_code,
   output logic              mem_req_valid,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data
);
   if (L1_WAYS < 1 || L2_WAYS < 1) begin : g_bad_ways
      $error("associativity must be at least one");
   end
   if ((L1_SETS & (L1_SETS - 1)) != 0 || (L2_SETS & (L2_SETS - 1)) != 0) begin : g_bad_sets
      $error("set counts must be powers of two");
   end
   if (ADDR_W < $clog2(L1_SETS) || ADDR_W < $clog2(L2_SETS)) begin : g_bad_addr
      $error("address too narrow for set index");
   end

   cx_state_e         st;
   logic [ADDR_W-1:0] cur_addr;

   logic              l1_hit, l2_hit;
   logic [W1W-1:0]    l1_way;
   logic [W2W-1:0]    l2_way;
   logic [DATA_W-1:0] l1_data, l2_data;
   logic              l1_ev_v, l2_ev_v;
   logic [ADDR_W-1:0] l1_ev_a, l2_ev_a;
   logic [DATA_W-1:0] l1_ev_d, l2_ev_d;

   logic look, l1_touch, swap, fill, l1_ins, l2_ins;
   assign look     = (st == CX_LOOK);
   assign l1_touch = look && l1_hit;
   assign swap     = look && !l1_hit && l2_hit;
   assign fill     = (st == CX_MEM) && mem_rsp_valid;
   assign l1_ins   = swap || fill;
   assign l2_ins   = l1_ins && l1_ev_v;

   cx_level #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(L1_SETS), .WAYS(L1_WAYS)) u_l1 (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(cur_addr), .lk_hit(l1_hit), .lk_way(l1_way), .lk_data(l1_data),
      .touch_en(l1_touch), .kill_en(1'b0),
      .ins_en(l1_ins), .ins_addr(cur_addr),
      .ins_data(fill ? mem_rsp_data : l2_data),
      .ev_valid(l1_ev_v), .ev_addr(l1_ev_a), .ev_data(l1_ev_d)
   );

   cx_level #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(L2_SETS), .WAYS(L2_WAYS)) u_l2 (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(cur_addr), .lk_hit(l2_hit), .lk_way(l2_way), .lk_data(l2_data),
      .touch_en(1'b0), .kill_en(swap),
      .ins_en(l2_ins), .ins_addr(l1_ev_a), .ins_data(l1_ev_d),
      .ev_valid(l2_ev_v), .ev_addr(l2_ev_a), .ev_data(l2_ev_d)
   );

   logic [W1W+DATA_W-1:0] unused_sig;
   assign unused_sig = {l1_way, l2_ev_d};
   logic [W2W-1:0] unused_l2w;
   assign unused_l2w = l2_way;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= CX_IDLE;
         cur_addr   <= '0;
         resp_valid <= 1'b0;
         resp_data  <= '0;
         resp_code  <= CX_L1_HIT;
      end else begin
         resp_valid <= 1'b0;
         case (st)
            CX_IDLE: if (req_valid) begin
               cur_addr <= req_addr;
               st       <= CX_LOOK;
            end
            CX_LOOK: begin
               if (l1_hit) begin
                  resp_valid <= 1'b1;
                  resp_data  <= l1_data;
                  resp_code  <= CX_L1_HIT;
                  st         <= CX_IDLE;
               end else if (l2_hit) begin
                  resp_valid <= 1'b1;
                  resp_data  <= l2_data;
                  resp_code  <= CX_L2_HIT;
                  st         <= CX_IDLE;
               end else begin
                  st <= CX_MEM;
               end
            end
            CX_MEM: if (mem_rsp_valid) begin
               resp_valid <= 1'b1;
               resp_data  <= mem_rsp_data;
               resp_code  <= CX_MISS;
               st         <= CX_IDLE;
            end
            default: st <= CX_IDLE;
         endcase
      end
   end

   assign req_ready     = (st == CX_IDLE);
   assign mem_req_valid = (st == CX_MEM);
   assign mem_req_addr  = cur_addr;

   // R7
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n) look |-> !(l1_hit && l2_hit))
      else $error("line valid in both levels");
   // R7
   spill_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l2_ins && l2_ev_v) |-> (l2_ev_a != l1_ev_a))
      else $error("spilled line already in second level");
   // R3
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)))
      else $error("memory request dropped early");
   // R3
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> !req_ready)
      else $error("request accepted while fetching");
   // R3
   miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resp_valid) && resp_code == CX_MISS |-> $past(mem_req_valid && mem_rsp_valid))
      else $error("miss reported without a fetch");
   // R2
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n) resp_valid |-> resp_code != 2'd3)
      else $error("illegal outcome code");
endmodule

// File: tb/sim_cx_excl_cache.sv
module sim_cx_excl_cache;
   localparam int AW = 8, DW = 16, S1 = 2, W1 = 2, S2 = 4, W2 = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready, resp_valid, mem_req_valid, mem_rsp_valid = 1'b0;
   logic [AW-1:0] req_addr = '0, mem_req_addr;
   logic [DW-1:0] resp_data, mem_rsp_data = '0;
   logic [1:0] resp_code;

   always #5 clk = ~clk;

   cx_excl_cache #(.ADDR_W(AW), .DATA_W(DW), .L1_SETS(S1), .L1_WAYS(W1),
                   .L2_SETS(S2), .L2_WAYS(W2)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
      .resp_code(resp_code), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit wd = 1'b0;

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         wd = 1'b1;
         n_bad++;
         $display("FAIL watchdog: run hung act=%0d exp=<150000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return {a ^ 8'hA5, a + 8'd17};
   endfunction

   // reference: per-set recency lists, most recent first
   logic [AW-1:0] m1 [S1][W1];
   int            n1 [S1];
   logic [AW-1:0] m2 [S2][W2];
   int            n2 [S2];

   task automatic l1_front(input int s, input logic [AW-1:0] a, output bit ev, output logic [AW-1:0] ea);
      ev = 1'b0; ea = '0;
      if (n1[s] == W1) begin ev = 1'b1; ea = m1[s][W1-1]; n1[s]--; end
      for (int i = n1[s]; i > 0; i--) m1[s][i] = m1[s][i-1];
      m1[s][0] = a; n1[s]++;
   endtask

   task automatic l2_front(input int s, input logic [AW-1:0] a);
      if (n2[s] == W2) n2[s]--;
      for (int i = n2[s]; i > 0; i--) m2[s][i] = m2[s][i-1];
      m2[s][0] = a; n2[s]++;
   endtask

   task automatic model_access(input logic [AW-1:0] a, output int code);
      int s1, s2, p, q;
      bit ev;
      logic [AW-1:0] ea;
      s1 = int'(a) % S1; s2 = int'(a) % S2; p = -1; q = -1;
      for (int i = 0; i < n1[s1]; i++) if (m1[s1][i] == a) p = i;
      for (int i = 0; i < n2[s2]; i++) if (m2[s2][i] == a) q = i;
      if (p >= 0) begin
         for (int i = p; i < n1[s1] - 1; i++) m1[s1][i] = m1[s1][i+1];
         n1[s1]--;
         l1_front(s1, a, ev, ea);
         code = 0;
      end else begin
         if (q >= 0) begin
            for (int i = q; i < n2[s2] - 1; i++) m2[s2][i] = m2[s2][i+1];
            n2[s2]--;
            code = 1;
         end else code = 2;
         l1_front(s1, a, ev, ea);
         if (ev) l2_front(int'(ea) % S2, ea);
      end
   endtask

   task automatic access(input logic [AW-1:0] a, input string tag);
      int exp_code, waited;
      bit saw_mem;
      model_access(a, exp_code);
      @(negedge clk);
      chk(req_ready == 1'b1, {tag, " R3 ready idle"}, int'(req_ready), 1);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0; waited = 1; saw_mem = 1'b0;
      while (!resp_valid && !wd) begin
         if (mem_req_valid) begin
            int d;
            saw_mem = 1'b1;
            chk(mem_req_addr == a, {tag, " R3 fetch address"}, int'(mem_req_addr), int'(a));
            chk(!req_ready, {tag, " R3 busy during fetch"}, int'(req_ready), 0);
            d = int'($urandom_range(0, 3));
            for (int k = 0; k < d; k++) begin
               @(negedge clk);
               chk(mem_req_valid && mem_req_addr == a, {tag, " R3 request held"}, int'(mem_req_valid), 1);
            end
            mem_rsp_valid = 1'b1; mem_rsp_data = memf(a);
            @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_data = '0;
         end else begin
            @(negedge clk);
            waited++;
         end
      end
      chk(int'(resp_code) == exp_code, {tag, " outcome code"}, int'(resp_code), exp_code);
      chk(resp_data == memf(a), {tag, " R10 data"}, int'(resp_data), int'(memf(a)));
      chk(saw_mem == (exp_code == 2), {tag, " R2 memory use"}, int'(saw_mem), int'(exp_code == 2));
      if (exp_code != 2) chk(waited == 2, {tag, " R2 latency"}, waited, 2);
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int s = 0; s < S1; s++) n1[s] = 0;
      for (int s = 0; s < S2; s++) n2[s] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
      chk(resp_valid == 1'b0, "R1 resp_valid", int'(resp_valid), 0);
      chk(mem_req_valid == 1'b0, "R1 mem_req_valid", int'(mem_req_valid), 0);

      access(8'h10, "R1 first miss");
      access(8'h10, "R4 refetch hits L1");
      access(8'h20, "R3 miss");
      access(8'h10, "R8 touch");
      access(8'h30, "R8 evict LRU 0x20");
      access(8'h10, "R8 MRU kept");
      access(8'h20, "R5 victim in L2");
      access(8'h20, "R6 moved up");
      access(8'h30, "R6 victim moved down");
      // R9 / R11: more lines than both levels hold through one set pair
      for (int i = 0; i < W1 + W2 + 1; i++) access(8'h80 + 8'(4 * i), "R11 load");
      access(8'h84, "R11 retained in L2");
      access(8'h80, "R9 dropped line");
      access(8'h88, "R9 neighbour");
      // random traffic over a small pool
      for (int i = 0; i < 3000 && !wd; i++) begin
         logic [AW-1:0] a;
         a = 8'($urandom_range(0, 47));
         if ($urandom_range(0, 3) == 0) a = a & 8'h0C;
         access(a, "R8 random");
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule